// File: doc/BRIEF.md
# Row/Column Selected Static RAM Grid

This block is a small static memory whose one-bit storage cells form a two-dimensional grid. Each access works out a row line and a column line from separate parts of the address. A cell takes part in a read or a write only where its row line and its column line are both high. Chip select enables the column decoder. When chip select is low, every column line stays low and no cell can be reached.

Read data is the OR of every selected cell, passed through an output enable. That enable is high only for a read with chip select high. When it is low, the data bus is held at zero and a separate valid flag is low. Writes take effect on the rising clock edge and reach only the cells that the address selects.

One parameter picks the word organisation on the same four-by-four grid. With one bit per word, the grid holds sixteen words and the low address bits pick a single column. With two bits per word, it holds eight words: each column-decoder output drives a pair of adjacent columns, and the lower column of the pair holds data bit 0.

Top module: `cs_ram_array`

## Requirements
- R1: A synchronous active-high reset clears every cell, so any read after reset returns all zeros with the valid flag high.
- R2: With chip select low, the data output is zero and the valid flag is low. A write strobe given in that cycle changes no stored word.
- R3: While a write is in progress (chip select and write both high), the data output is zero and the valid flag is low.
- R4: A read (chip select high, write low) shows the stored word at the address in the same cycle, with the valid flag high. Reading never alters stored contents.
- R5: A write stores the data input into the addressed word on the rising clock edge. Every other word keeps its value.
- R6: In the two-bit organisation, the address is 3 bits wide and both data bits are written and read back together as one word of 8.
- R7: In the one-bit organisation, the address is 4 bits wide (upper two bits select the row, lower two the column) and all 16 words hold independent values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all cells |
| addr | input | AW | Word address: row bits above column-select bits |
| cs | input | 1 | Chip select; enables the column decoder |
| we | input | 1 | High for write, low for read |
| din | input | DW | Write data |
| dout | output | DW | Read data, zero when not enabled |
| dout_vld | output | 1 | High when dout carries a read word |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the default one-bit-per-word setting (WORD_LG = 0), which exercises all 16 cells through single-column selection. The other uses WORD_LG = 1, which reaches the paired-column path where two cells answer one address. Running both against a behavioural array model every cycle covers pattern fills, full read-back, strobes with chip select low and a mid-run reset in both organisations.

// File: rtl/cs_ram_pkg.sv
package cs_ram_pkg;
  // One-hot line for a binary select value
  function automatic logic [15:0] onehot16(input int unsigned sel);
    logic [15:0] v;
    v = '0;
    v[sel[3:0]] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/cs_ram_row_dec.sv
module cs_ram_row_dec #(
  parameter int SEL_W = 2,
  localparam int LINES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  output logic [LINES-1:0] line
);
  logic [15:0] full;
  always_comb full = cs_ram_pkg::onehot16(int'(sel));
  assign line = full[LINES-1:0];
endmodule

// File: rtl/cs_ram_col_dec.sv
module cs_ram_col_dec #(
  parameter int SEL_W   = 2,
  parameter int GROUP_LG = 0,
  localparam int NCOL   = 1 << (SEL_W + GROUP_LG)
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [NCOL-1:0]  line
);
  // Each decoded output drives a group of 2**GROUP_LG adjacent columns
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign line[c] = en && (int'(sel) == (c >> GROUP_LG));
  end
endmodule

// File: rtl/cs_ram_cell.sv
module cs_ram_cell (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (wr) q <= d;
  end
endmodule

// File: rtl/cs_ram_array.sv
module cs_ram_array #(
  parameter int ROW_LG  = 2,
  parameter int COL_LG  = 2,
  parameter int WORD_LG = 0,
  localparam int DW     = 1 << WORD_LG,
  localparam int SEL_LG = COL_LG - WORD_LG,
  localparam int AW     = ROW_LG + SEL_LG,
  localparam int NROW   = 1 << ROW_LG,
  localparam int NCOL   = 1 << COL_LG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          cs,
  input  logic          we,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_vld
);
  logic [ROW_LG-1:0]    row_sel;
  logic [SEL_LG-1:0]    col_sel;
  logic [NROW-1:0]      row_line;
  logic [NCOL-1:0]      col_line;
  logic [NROW*NCOL-1:0] cell_q;
  logic [DW-1:0]        or_bus;
  logic                 out_en;

  assign row_sel = addr[AW-1 -: ROW_LG];
  assign col_sel = addr[SEL_LG-1:0];

  cs_ram_row_dec #(.SEL_W(ROW_LG)) u_row (
    .sel  (row_sel),
    .line (row_line)
  );

  cs_ram_col_dec #(.SEL_W(SEL_LG), .GROUP_LG(WORD_LG)) u_col (
    .en   (cs),
    .sel  (col_sel),
    .line (col_line)
  );

  for (genvar r = 0; r < NROW; r++) begin : g_row
    for (genvar c = 0; c < NCOL; c++) begin : g_cell
      cs_ram_cell u_cell (
        .clk (clk),
        .rst (rst),
        .wr  (we && row_line[r] && col_line[c]),
        .d   (din[c % DW]),
        .q   (cell_q[r*NCOL + c])
      );
    end
  end

  // Wired-OR of all selected cells, one OR per data bit lane
  always_comb begin
    or_bus = '0;
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++)
        if (row_line[r] && col_line[c])
          or_bus[c % DW] = or_bus[c % DW] | cell_q[r*NCOL + c];
  end

  assign out_en   = cs && !we;
  assign dout     = out_en ? or_bus : '0;
  assign dout_vld = out_en;
endmodule

// File: rtl/cs_ram_chk.sv
module cs_ram_chk #(
  parameter int AW = 4,
  parameter int DW = 1
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr,
  input logic          cs,
  input logic          we,
  input logic [DW-1:0] din,
  input logic [DW-1:0] dout,
  input logic          dout_vld
);
  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    !cs |-> (dout == '0 && !dout_vld));

  a_r3_write_hides_out: assert property (@(posedge clk) disable iff (rst)
    (cs && we) |-> (dout == '0 && !dout_vld));

  a_r4_read_valid: assert property (@(posedge clk) disable iff (rst)
    (cs && !we) |-> dout_vld);

  a_r4_read_no_change: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && $past(cs && !we && !rst) && addr == $past(addr))
      |-> dout == $past(dout));

  a_r5_write_then_read: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && $past(cs && we && !rst) && addr == $past(addr))
      |-> dout == $past(din));

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && cs && !we) |-> dout == '0);
endmodule

bind cs_ram_array cs_ram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .cs(cs), .we(we),
  .din(din), .dout(dout), .dout_vld(dout_vld)
);

// File: tb/cs_ram_array_tb.sv
module cs_ram_array_tb;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a_i = '0;
  logic       cs_i = 1'b0;
  logic       we_i = 1'b0;
  logic [1:0] d_i = '0;
  logic       dout_n;
  logic       vld_n;
  logic [1:0] dout_w;
  logic       vld_w;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  bit mem_n [16];
  logic [1:0] mem_w [8];

  always #(CLK_NS/2) clk = ~clk;

  cs_ram_array #(.WORD_LG(0)) u_dut (
    .clk(clk), .rst(rst), .addr(a_i), .cs(cs_i), .we(we_i),
    .din(d_i[0]), .dout(dout_n), .dout_vld(vld_n)
  );

  cs_ram_array #(.WORD_LG(1)) u_dut_pair (
    .clk(clk), .rst(rst), .addr(a_i[2:0]), .cs(cs_i), .we(we_i),
    .din(d_i), .dout(dout_w), .dout_vld(vld_w)
  );

  task automatic compare(input string tag, input string tag_w);
    logic       ev;
    logic       en;
    logic [1:0] ew;
    ev = cs_i && !we_i;
    en = ev ? mem_n[a_i] : 1'b0;
    ew = ev ? mem_w[a_i[2:0]] : 2'b00;
    vectors++;
    if (dout_n !== en || vld_n !== ev) begin
      errors++;
      $display("FAIL %s narrow addr=%0d dout=%b vld=%b expected dout=%b vld=%b",
               tag, a_i, dout_n, vld_n, en, ev);
    end
    vectors++;
    if (dout_w !== ew || vld_w !== ev) begin
      errors++;
      $display("FAIL %s pair addr=%0d dout=%b vld=%b expected dout=%b vld=%b",
               tag_w, a_i[2:0], dout_w, vld_w, ew, ev);
    end
  endtask

  task automatic step(input logic r, input logic c, input logic w,
                      input logic [3:0] a, input logic [1:0] d,
                      input string tag, input string tag_w);
    @(negedge clk);
    rst = r; cs_i = c; we_i = w; a_i = a; d_i = d;
    #1;
    if (!r) compare(tag, tag_w);
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < 16; i++) mem_n[i] = 1'b0;
      for (int i = 0; i < 8; i++)  mem_w[i] = 2'b00;
    end else if (c && w) begin
      mem_n[a] = d[0];
      mem_w[a[2:0]] = d;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 0, 0, "R1", "R1");
    step(1, 0, 0, 0, 0, "R1", "R1");
    // R1: all words read zero after reset
    for (int a = 0; a < 16; a++) step(0, 1, 0, 4'(a), 0, "R1", "R1");
    // R5/R3: fill distinct patterns; output hidden during writes
    for (int a = 0; a < 16; a++)
      step(0, 1, 1, 4'(a), 2'(a ^ (a >> 2) ^ 1), "R3", "R3");
    // R7/R6: read everything back
    for (int a = 0; a < 16; a++) step(0, 1, 0, 4'(a), 0, "R7", "R6");
    // R2: strobes with chip select low, then confirm nothing changed
    for (int a = 0; a < 16; a++) step(0, 0, 1, 4'(a), ~2'(a ^ (a >> 2) ^ 1), "R2", "R2");
    for (int a = 0; a < 16; a++) step(0, 1, 0, 4'(a), 0, "R2", "R2");
    // R4: repeated reads of one word
    for (int i = 0; i < 4; i++) step(0, 1, 0, 4'd9, 0, "R4", "R4");
    // R5: write one word, neighbours untouched
    step(0, 1, 1, 4'd6, 2'b10, "R5", "R5");
    for (int a = 0; a < 16; a++) step(0, 1, 0, 4'(a), 0, "R5", "R6");
    // R4: random mix
    for (int i = 0; i < 600; i++)
      step(0, 1'($urandom), 1'($urandom), 4'($urandom), 2'($urandom), "R4", "R4");
    // R1: reset mid-run clears everything
    step(1, 1, 0, 0, 0, "R1", "R1");
    for (int a = 0; a < 16; a++) step(0, 1, 0, 4'(a), 0, "R1", "R1");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule